// File: doc/BRIEF.md
# Memory Test Pattern Generator

This block supplies the data word that a memory self-test writes into each location, or expects to read back from it. The word is 36 bits wide and is presented as two 16-bit fields and one 4-bit field. A one-hot select picks one of four patterns: all zeros, all ones, an alternating checkerboard, or pseudo-random data. A fill strobe asks for the next word.

Random words come from a 16-bit linear congruential generator. Its multiply is built from shifts and adds. A self-test writes a whole region in one pass and then checks the region in a second pass. To support this, the generator state can be saved when the write pass begins and reloaded when the read pass begins. The read pass then reproduces exactly the word sequence that was written. The checkerboard phase returns to its first value whenever a pass begins.

Address sequencing, memory access and comparison belong to the surrounding controller. A separate advance input lets that controller perturb the generator between pattern rounds without taking a word.

Top module: `mtp_patgen`

## Requirements
- R1: After reset all three fields read zero, `done` is low, and both the generator state and the saved state hold the seed 83. As a result, the first random word after reset has field 0 equal to 0xCFB8.
- R2: `pat_sel` is one-hot: bit 0 selects zeros, bit 1 ones, bit 2 checkerboard and bit 3 random. An accepted zeros fill sets all three fields to zero at the next clock edge, and `done` is high for exactly that one cycle.
- R3: An accepted ones fill sets field 0 and field 1 to 0xFFFF and field 2 to 0xF at the next clock edge, with a one-cycle `done`.
- R4: Each accepted checkerboard fill completes in one cycle with `done`. Successive fills alternate between 0xAAAA and 0x5555 in fields 0 and 1. Field 2 always carries the low nibble of that value (0xA or 0x5). The first checkerboard fill after reset gives 0xAAAA.
- R5: A `save` or `restore` pulse returns the checkerboard phase to 0xAAAA. This also applies to a checkerboard fill issued in the same cycle as the pulse.
- R6: An accepted random fill takes three clock edges. Field 0 receives the first new generator output at the first edge, field 1 the second output at the second edge, and field 2 the low 4 bits of the third output at the third edge. `done` is high only after the third edge.
- R7: Each generator step computes x ← (2053·x + 13849) mod 2^16.
- R8: `save` copies the generator state held before any step in that cycle. `restore` reloads the saved state, and it takes effect before any step in the same cycle. When `save` and `restore` are both high, the saved state does not change.
- R9: `advance` steps the generator once without changing the fields. It is dropped while a random fill is in progress and in the cycle a random fill is accepted. It is honoured alongside a zeros, ones or checkerboard fill.
- R10: A fill whose select is not exactly one-hot (no bit set, or several bits set) is ignored: the fields hold and `done` stays low.
- R11: A fill request that arrives while a random fill is in progress is ignored. The random sequence completes unchanged and no extra `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill | input | 1 | Request the next data word |
| pat_sel | input | 4 | One-hot pattern select (zeros, ones, checker, random) |
| advance | input | 1 | Step the generator without producing a word |
| save | input | 1 | Checkpoint generator state; marks a write-pass start |
| restore | input | 1 | Reload checkpointed state; marks a read-pass start |
| word0 | output | 16 | Field 0 of the data word |
| word1 | output | 16 | Field 1 of the data word |
| word2 | output | 4 | Field 2 of the data word |
| done | output | 1 | One-cycle pulse when a fill has completed |

## Verification
The case most likely to hide an error is a pass-boundary pulse that arrives in the same cycle as a random fill. Restore combined with fill must give a first word computed from the reloaded state. Save combined with fill must checkpoint the state from before the step. The bench drives both combinations. It then runs a second pass from the checkpoint and compares the words it gets against an independent multiply-based model of the generator. It also starts random fills with `advance` high in the acceptance cycle and in a busy cycle, and judges from the next fill's words that no extra step occurred.

// File: rtl/mtp_pkg.sv
package mtp_pkg;

   localparam int SEL_W    = 4;
   localparam int SEL_ZERO = 0;
   localparam int SEL_ONE  = 1;
   localparam int SEL_CHK  = 2;
   localparam int SEL_RAND = 3;

   typedef enum logic [2:0] {
      FK_NONE,
      FK_ZERO,
      FK_ONE,
      FK_CHK,
      FK_RAND
   } fill_kind_e;

   // Only an exact one-hot select names a pattern.
   function automatic fill_kind_e decode_sel(input logic [SEL_W-1:0] s);
      fill_kind_e k;
      k = FK_NONE;
      if ($countones(s) == 1) begin
         if (s[SEL_ZERO])      k = FK_ZERO;
         else if (s[SEL_ONE])  k = FK_ONE;
         else if (s[SEL_CHK])  k = FK_CHK;
         else if (s[SEL_RAND]) k = FK_RAND;
      end
      return k;
   endfunction

endpackage

// File: rtl/mtp_lcg.sv
module mtp_lcg #(
   parameter int W         = 16,
   parameter int SEED      = 83,
   parameter int MUL       = 2053,
   parameter int INC       = 13849,
   parameter int SH_A      = 2,
   parameter int SH_B      = 11,
   parameter bit SHIFT_ADD = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         save,
   input  logic         restore,
   output logic [W-1:0] x_q,
   output logic [W-1:0] saved_q,
   output logic [W-1:0] next_val
);

   localparam logic [W-1:0] SEED_V = W'(SEED);
   localparam logic [W-1:0] INC_V  = W'(INC);

   logic [W-1:0] x_eff;

   // Restore is applied first; any step in the same cycle uses the reloaded value.
   assign x_eff = restore ? saved_q : x_q;

   if (SHIFT_ADD) begin : g_shift_add
      if (MUL != 1 + (1 << SH_A) + (1 << SH_B)) begin : g_bad_mul
         $error("mtp_lcg: MUL does not match 1 + 2^SH_A + 2^SH_B");
      end
      assign next_val = x_eff + (x_eff << SH_A) + (x_eff << SH_B) + INC_V;
   end else begin : g_multiply
      localparam logic [W-1:0] MUL_V = W'(MUL);
      assign next_val = W'(x_eff * MUL_V) + INC_V;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_q     <= SEED_V;
         saved_q <= SEED_V;
      end else begin
         if (step)         x_q <= next_val;
         else if (restore) x_q <= saved_q;
         if (save && !restore) saved_q <= x_q;
      end
   end

endmodule

// File: rtl/mtp_chk_phase.sv
module mtp_chk_phase (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic flip,
   output logic phase_eff
);

   logic phase_q;

   // A pass-start pulse acts before a same-cycle checker fill.
   assign phase_eff = clear ? 1'b0 : phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      phase_q <= 1'b0;
      else if (flip)   phase_q <= ~phase_eff;
      else if (clear)  phase_q <= 1'b0;
   end

endmodule

// File: rtl/mtp_fill_ctrl.sv
module mtp_fill_ctrl
   import mtp_pkg::*;
#(
   parameter int NSTEP = 3,
   localparam int IDXW = (NSTEP > 1) ? $clog2(NSTEP) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fill,
   input  logic [SEL_W-1:0] sel,
   input  logic             advance,
   output fill_kind_e       kind,
   output logic             busy,
   output logic [IDXW-1:0]  rand_idx,
   output logic             gen_step,
   output logic             done
);

   localparam logic [IDXW-1:0] LAST = IDXW'(NSTEP - 1);

   logic [IDXW-1:0] cnt_q;
   logic            rand_start;
   logic            rand_load;
   logic            short_fill;

   assign kind       = (fill && !busy) ? decode_sel(sel) : FK_NONE;
   assign rand_start = (kind == FK_RAND);
   assign short_fill = (kind == FK_ZERO) || (kind == FK_ONE) || (kind == FK_CHK);
   assign rand_load  = rand_start || busy;
   assign rand_idx   = busy ? cnt_q : '0;
   // An advance that coincides with a random step merges into that step.
   assign gen_step   = rand_load || advance;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
         done  <= 1'b0;
      end else begin
         done <= short_fill || (busy && cnt_q == LAST);
         if (rand_start) begin
            busy  <= (NSTEP > 1);
            cnt_q <= IDXW'(1);
         end else if (busy) begin
            if (cnt_q == LAST) begin
               busy  <= 1'b0;
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + IDXW'(1);
            end
         end
      end
   end

endmodule

// File: rtl/mtp_patgen.sv
module mtp_patgen
   import mtp_pkg::*;
#(
   parameter int W         = 16,
   parameter int N         = 4,
   parameter int SEED      = 83,
   parameter int MUL       = 2053,
   parameter int INC       = 13849,
   parameter int SH_A      = 2,
   parameter int SH_B      = 11,
   parameter bit SHIFT_ADD = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fill,
   input  logic [3:0]   pat_sel,
   input  logic         advance,
   input  logic         save,
   input  logic         restore,
   output logic [W-1:0] word0,
   output logic [W-1:0] word1,
   output logic [N-1:0] word2,
   output logic         done
);

   localparam int NFIELD = 3;
   localparam int IDXW   = $clog2(NFIELD);
   localparam logic [W-1:0] ONES_V = '1;
   localparam logic [W-1:0] CHK_HI = {(W/2){2'b10}};
   localparam logic [W-1:0] CHK_LO = ~CHK_HI;

   if (W < 4 || (W % 2) != 0) begin : g_bad_w
      $error("mtp_patgen: W must be even and at least 4");
   end
   if (N < 1 || N > W) begin : g_bad_n
      $error("mtp_patgen: N must lie in 1..W");
   end

   fill_kind_e      kind;
   logic            busy;
   logic [IDXW-1:0] rand_idx;
   logic            gen_step;
   logic [W-1:0]    gen_x;
   logic [W-1:0]    saved_x;
   logic [W-1:0]    gen_next;
   logic            phase;
   logic [W-1:0]    chk_val;

   mtp_fill_ctrl #(.NSTEP(NFIELD)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .fill     (fill),
      .sel      (pat_sel),
      .advance  (advance),
      .kind     (kind),
      .busy     (busy),
      .rand_idx (rand_idx),
      .gen_step (gen_step),
      .done     (done)
   );

   mtp_lcg #(
      .W(W), .SEED(SEED), .MUL(MUL), .INC(INC),
      .SH_A(SH_A), .SH_B(SH_B), .SHIFT_ADD(SHIFT_ADD)
   ) u_lcg (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (gen_step),
      .save     (save),
      .restore  (restore),
      .x_q      (gen_x),
      .saved_q  (saved_x),
      .next_val (gen_next)
   );

   mtp_chk_phase u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (save || restore),
      .flip      (kind == FK_CHK),
      .phase_eff (phase)
   );

   assign chk_val = phase ? CHK_LO : CHK_HI;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word0 <= '0;
         word1 <= '0;
         word2 <= '0;
      end else begin
         unique case (kind)
            FK_ZERO: begin
               word0 <= '0;
               word1 <= '0;
               word2 <= '0;
            end
            FK_ONE: begin
               word0 <= ONES_V;
               word1 <= ONES_V;
               word2 <= ONES_V[N-1:0];
            end
            FK_CHK: begin
               word0 <= chk_val;
               word1 <= chk_val;
               word2 <= chk_val[N-1:0];
            end
            FK_RAND: word0 <= gen_next;
            default: ;
         endcase
         if (busy) begin
            if (rand_idx == IDXW'(1)) word1 <= gen_next;
            if (rand_idx == IDXW'(2)) word2 <= gen_next[N-1:0];
         end
      end
   end

endmodule

// File: rtl/mtp_patgen_chk.sv
module mtp_patgen_chk #(
   parameter int W   = 16,
   parameter int N   = 4,
   parameter int MUL = 2053,
   parameter int INC = 13849
) (
   input logic         clk,
   input logic         rst_n,
   input logic         fill,
   input logic [3:0]   pat_sel,
   input logic         advance,
   input logic         save,
   input logic         restore,
   input logic [W-1:0] word0,
   input logic [W-1:0] word1,
   input logic [N-1:0] word2,
   input logic         done,
   input logic         busy,
   input logic [W-1:0] gen_x,
   input logic [W-1:0] saved_x
);

   localparam logic [W-1:0] CA = {(W/2){2'b10}};
   localparam logic [W-1:0] C5 = ~CA;

   a_r2_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
      fill && !busy && pat_sel == 4'b0001 |=> word0 == '0 && word1 == '0 && word2 == '0 && done);

   a_r3_ones_fill: assert property (@(posedge clk) disable iff (!rst_n)
      fill && !busy && pat_sel == 4'b0010 |=> (&word0) && (&word1) && (&word2) && done);

   a_r4_checker_shape: assert property (@(posedge clk) disable iff (!rst_n)
      fill && !busy && pat_sel == 4'b0100 |=>
         (word0 == CA || word0 == C5) && word1 == word0 && word2 == word0[N-1:0] && done);

   a_r5_phase_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (save || restore) && fill && !busy && pat_sel == 4'b0100 |=> word0 == CA);

   a_r6_rand_busy: assert property (@(posedge clk) disable iff (!rst_n)
      fill && !busy && pat_sel == 4'b1000 |=> busy && !done);

   a_r7_step_formula: assert property (@(posedge clk) disable iff (!rst_n)
      advance && !busy && !restore && !fill |=> gen_x == W'($past(gen_x) * MUL + INC));

   a_r8_save_capture: assert property (@(posedge clk) disable iff (!rst_n)
      save && !restore |=> saved_x == $past(gen_x));

   a_r8_restore_load: assert property (@(posedge clk) disable iff (!rst_n)
      restore && !busy && !advance && !(fill && pat_sel == 4'b1000) |=> gen_x == $past(saved_x));

   a_r10_nosel_hold: assert property (@(posedge clk) disable iff (!rst_n)
      fill && !busy && pat_sel == 4'b0000 |=> $stable(word0) && $stable(word1) && $stable(word2) && !done);

endmodule

bind mtp_patgen mtp_patgen_chk #(.W(W), .N(N), .MUL(MUL), .INC(INC)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .fill    (fill),
   .pat_sel (pat_sel),
   .advance (advance),
   .save    (save),
   .restore (restore),
   .word0   (word0),
   .word1   (word1),
   .word2   (word2),
   .done    (done),
   .busy    (busy),
   .gen_x   (gen_x),
   .saved_x (saved_x)
);

// File: tb/sim_mtp_patgen.sv
`timescale 1ns/1ps
module sim_mtp_patgen;

   localparam logic [3:0] S_ZERO = 4'b0001;
   localparam logic [3:0] S_ONE  = 4'b0010;
   localparam logic [3:0] S_CHK  = 4'b0100;
   localparam logic [3:0] S_RAND = 4'b1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fill = 1'b0;
   logic [3:0]  pat_sel = 4'b0000;
   logic        advance = 1'b0;
   logic        save = 1'b0;
   logic        restore = 1'b0;
   logic [15:0] word0;
   logic [15:0] word1;
   logic [3:0]  word2;
   logic        done;

   int total = 0;
   int fails = 0;

   logic [15:0] xm = 16'd83;
   logic [15:0] sm = 16'd83;
   logic [15:0] last_w0;

   always #2.5 clk = ~clk;

   mtp_patgen u0 (
      .clk(clk), .rst_n(rst_n), .fill(fill), .pat_sel(pat_sel),
      .advance(advance), .save(save), .restore(restore),
      .word0(word0), .word1(word1), .word2(word2), .done(done)
   );

   function automatic logic [15:0] lcg_m(input logic [15:0] x);
      return 16'((32'(x) * 2053 + 13849) % 65536);
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic f, input logic [3:0] s, input logic adv,
                        input logic sv, input logic rs);
      fill = f; pat_sel = s; advance = adv; save = sv; restore = rs;
      @(negedge clk);
      fill = 1'b0; pat_sel = 4'b0000; advance = 1'b0; save = 1'b0; restore = 1'b0;
   endtask

   task automatic rand_fill(input string req, input logic sv, input logic rs,
                            input logic adv, input logic mid_adv, input logic mid_fill);
      logic [15:0] e0, e1, e2;
      if (rs) xm = sm;
      else if (sv) sm = xm;
      e0 = lcg_m(xm); e1 = lcg_m(e0); e2 = lcg_m(e1); xm = e2;
      last_w0 = e0;
      drive(1'b1, S_RAND, adv, sv, rs);
      check({req, " field0"}, word0, e0);
      check({req, " done early"}, {15'd0, done}, 16'd0);
      fill = mid_fill; pat_sel = mid_fill ? S_ZERO : 4'b0000; advance = mid_adv;
      @(negedge clk);
      fill = 1'b0; pat_sel = 4'b0000; advance = 1'b0;
      check({req, " field1"}, word1, e1);
      check({req, " field0 held"}, word0, e0);
      @(negedge clk);
      check({req, " field2"}, {12'd0, word2}, {12'd0, e2[3:0]});
      check({req, " done"}, {15'd0, done}, 16'd1);
   endtask

   task automatic t_reset();
      check("R1 reset field0", word0, 16'h0000);
      check("R1 reset field1", word1, 16'h0000);
      check("R1 reset field2", {12'd0, word2}, 16'h0000);
      check("R1 reset done", {15'd0, done}, 16'd0);
   endtask

   task automatic t_ones_zeros();
      drive(1'b1, S_ONE, 1'b0, 1'b0, 1'b0);
      check("R3 ones field0", word0, 16'hFFFF);
      check("R3 ones field1", word1, 16'hFFFF);
      check("R3 ones field2", {12'd0, word2}, 16'h000F);
      check("R3 ones done", {15'd0, done}, 16'd1);
      @(negedge clk);
      check("R3 done one cycle", {15'd0, done}, 16'd0);
      drive(1'b1, S_ZERO, 1'b0, 1'b0, 1'b0);
      check("R2 zeros field0", word0, 16'h0000);
      check("R2 zeros field1", word1, 16'h0000);
      check("R2 zeros field2", {12'd0, word2}, 16'h0000);
      check("R2 zeros done", {15'd0, done}, 16'd1);
      @(negedge clk);
      check("R2 done one cycle", {15'd0, done}, 16'd0);
   endtask

   task automatic t_checker();
      drive(1'b1, S_CHK, 1'b0, 1'b0, 1'b0);
      check("R4 first checker", word0, 16'hAAAA);
      check("R4 checker field2", {12'd0, word2}, 16'h000A);
      check("R4 checker done", {15'd0, done}, 16'd1);
      drive(1'b1, S_CHK, 1'b0, 1'b0, 1'b0);
      check("R4 second checker", word1, 16'h5555);
      check("R4 second field2", {12'd0, word2}, 16'h0005);
      drive(1'b1, S_CHK, 1'b0, 1'b0, 1'b0);
      check("R4 third checker", word0, 16'hAAAA);
      drive(1'b0, 4'b0000, 1'b0, 1'b1, 1'b0);
      sm = xm;
      drive(1'b1, S_CHK, 1'b0, 1'b0, 1'b0);
      check("R5 save clears phase", word0, 16'hAAAA);
      drive(1'b1, S_CHK, 1'b0, 1'b0, 1'b0);
      check("R5 phase runs on", word0, 16'h5555);
      drive(1'b1, S_CHK, 1'b0, 1'b0, 1'b1);
      xm = sm;
      check("R5 restore with fill clears", word0, 16'hAAAA);
   endtask

   task automatic t_nosel();
      drive(1'b1, 4'b0000, 1'b0, 1'b0, 1'b0);
      check("R10 empty select holds", word0, 16'hAAAA);
      check("R10 empty select no done", {15'd0, done}, 16'd0);
      drive(1'b1, 4'b0110, 1'b0, 1'b0, 1'b0);
      check("R10 multi select holds", word1, 16'hAAAA);
      check("R10 multi select field2", {12'd0, word2}, 16'h000A);
      check("R10 multi select no done", {15'd0, done}, 16'd0);
   endtask

   task automatic t_random_seed();
      rand_fill("R6", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      check("R1 seed gives first word", word0, 16'hCFB8);
      check("R7 step formula", word1, lcg_m(16'hCFB8));
   endtask

   task automatic t_replay();
      logic [15:0] first;
      drive(1'b0, 4'b0000, 1'b0, 1'b1, 1'b0);
      sm = xm;
      rand_fill("R8 write pass a", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      first = word0;
      rand_fill("R8 write pass b", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      drive(1'b0, 4'b0000, 1'b0, 1'b0, 1'b1);
      xm = sm;
      rand_fill("R8 read pass", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      check("R8 replay matches", word0, first);
      rand_fill("R8 restore with fill", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      check("R8 same-cycle restore replay", word0, first);
      drive(1'b0, 4'b0000, 1'b0, 1'b1, 1'b1);
      xm = sm;
      rand_fill("R8 save with restore keeps", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      check("R8 checkpoint kept", word0, first);
   endtask

   task automatic t_save_same();
      rand_fill("R8 save with fill", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      rand_fill("R8 after save", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      rand_fill("R8 restore pre-step", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_advance();
      drive(1'b0, 4'b0000, 1'b1, 1'b0, 1'b0);
      xm = lcg_m(xm);
      rand_fill("R9 advance alone", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      rand_fill("R9 advance with random start", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      rand_fill("R9 advance while busy", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      rand_fill("R9 no stray step", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      drive(1'b1, S_ZERO, 1'b1, 1'b0, 1'b0);
      xm = lcg_m(xm);
      check("R9 advance with zeros fill", word0, 16'h0000);
      rand_fill("R9 advance with zeros stepped", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_busy_fill();
      rand_fill("R11 fill while busy", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      @(negedge clk);
      check("R11 no extra done", {15'd0, done}, 16'd0);
      check("R11 field0 untouched", word0, last_w0);
   endtask

   initial begin
      #100us;
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ones_zeros();
      t_checker();
      t_nosel();
      t_random_seed();
      t_replay();
      t_save_same();
      t_advance();
      t_busy_fill();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule